// File: doc/BRIEF.md
# Register-Controlled Barrel Shifter with Carry Out

This block shifts a data word by an amount taken from a second register operand and reports the last bit shifted out as a carry. Four shift kinds are offered: logical left, logical right, arithmetic right and rotate right. Only the low byte of the amount operand counts. Each shift kind has its own carry rule for amounts of one word width and above.

A carry write enable goes with every result. It is low when the carry flag must keep its old value, which is the case for an amount of zero. Surrounding flag logic uses the enable to choose between the new carry and the stored flag. The path is combinational by default. Setting a parameter adds one register stage on the outputs.

Top module: `shift_carry_top`

## Requirements
- R1: Only bits [7:0] of `shAmt` affect the outputs; bits [31:8] have no effect.
- R2: With an amount of 0, `result` equals `dataIn` and `carryWe` is 0 for every shift kind.
- R3: Logical left (`shOp`=2'b00) by n in 1..31 gives `dataIn << n` and carry = `dataIn[32-n]`; n = 32 gives result 0 and carry `dataIn[0]`; n > 32 gives result 0 and carry 0; `carryWe` is 1 for every n ≥ 1.
- R4: Logical right (`shOp`=2'b01) by n in 1..31 gives `dataIn >> n` and carry = `dataIn[n-1]`; n = 32 gives 0 and carry `dataIn[31]`; n > 32 gives 0 and carry 0; `carryWe` is 1 for n ≥ 1.
- R5: Arithmetic right (`shOp`=2'b10) by n in 1..31 gives a sign-filled shift with carry = `dataIn[n-1]`; n ≥ 32 fills every bit with `dataIn[31]` and carry = `dataIn[31]`; `carryWe` is 1 for n ≥ 1.
- R6: Rotate right (`shOp`=2'b11) uses r = n mod 32; for r ≠ 0 the result is `dataIn` rotated right by r and carry = `dataIn[r-1]`.
- R7: Rotate right by a non-zero multiple of 32 leaves `result` equal to `dataIn`, sets carry to `dataIn[31]` and raises `carryWe`.
- R8: With `OUT_REG`=1, the outputs show the inputs presented one clock earlier; reset clears all outputs to 0. With `OUT_REG`=0, the outputs follow the inputs in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, used only by the output register stage |
| rstN | input | 1 | Active-low reset for the output register stage |
| dataIn | input | 32 | Word to be shifted |
| shAmt | input | 32 | Amount operand; only the low byte is used |
| shOp | input | 2 | Shift kind: 00 left, 01 logical right, 10 arithmetic right, 11 rotate right |
| result | output | 32 | Shifted word |
| carryOut | output | 1 | Carry value produced by the shift |
| carryWe | output | 1 | High when the carry flag must take `carryOut` |

## Verification
The bench builds two instances: one with `OUT_REG`=0 and one with `OUT_REG`=1, both using a 32-bit word and an 8-bit amount field. The combinational instance checks every amount from 0 to 255 with every shift kind against an independent model. This covers the exact-32 cases, the amounts above 32 and the rotate multiples of 32. The registered instance checks the one-cycle latency and the reset state. Amount operands with random upper bits confirm that bits above the low byte are ignored.

// File: rtl/shift_carry_pkg.sv
package shift_carry_pkg;
  typedef enum logic [1:0] {
    SH_LSL = 2'b00,
    SH_LSR = 2'b01,
    SH_ASR = 2'b10,
    SH_ROR = 2'b11
  } shKind_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic zeroAmt;   // amount field is zero
    logic exactW;    // amount equals the word width
    logic overW;     // amount exceeds the word width
    logic rorWrap;   // rotate by a non-zero multiple of the width
    logic carryWe;   // carry flag is to be written
  } shCtl_t;
endpackage

// File: rtl/shift_carry_ctrl.sv
module shift_carry_ctrl
  import shift_carry_pkg::*;
#(
  parameter int AMT_W = 8,
  parameter int DATA_W = 32
) (
  input  logic [AMT_W-1:0] amt,
  input  shKind_e          kind,
  output shCtl_t           ctl
);
  localparam int LOG_W = $clog2(DATA_W);

  logic [LOG_W-1:0] amtLow;
  assign amtLow = amt[LOG_W-1:0];

  always_comb begin
    ctl.zeroAmt = (amt == '0);
    ctl.exactW  = (32'(amt) == 32'(DATA_W));
    ctl.overW   = (32'(amt) > 32'(DATA_W));
    ctl.rorWrap = (kind == SH_ROR) && !ctl.zeroAmt && (amtLow == '0);
    ctl.carryWe = !ctl.zeroAmt;
  end
endmodule

// File: rtl/shift_carry_dp.sv
module shift_carry_dp
  import shift_carry_pkg::*;
#(
  parameter int AMT_W = 8,
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] din,
  input  logic [AMT_W-1:0]  amt,
  input  shKind_e           kind,
  input  shCtl_t            ctl,
  output logic [DATA_W-1:0] dout,
  output logic              cout
);
  localparam int LOG_W = $clog2(DATA_W);

  logic [LOG_W-1:0] n;
  logic [2*DATA_W-1:0] dbl;
  logic signBit;

  assign n = amt[LOG_W-1:0];
  assign signBit = din[DATA_W-1];
  assign dbl = {din, din};

  always_comb begin
    dout = din;
    cout = 1'b0;
    if (!ctl.zeroAmt) begin
      unique case (kind)
        SH_LSL: begin
          if (ctl.exactW) begin
            dout = '0;
            cout = din[0];
          end else if (ctl.overW) begin
            dout = '0;
            cout = 1'b0;
          end else begin
            dout = din << n;
            cout = din[DATA_W - 32'(n)];
          end
        end
        SH_LSR: begin
          if (ctl.exactW) begin
            dout = '0;
            cout = signBit;
          end else if (ctl.overW) begin
            dout = '0;
            cout = 1'b0;
          end else begin
            dout = din >> n;
            cout = din[n - 1'b1];
          end
        end
        SH_ASR: begin
          if (ctl.exactW || ctl.overW) begin
            dout = {DATA_W{signBit}};
            cout = signBit;
          end else begin
            dout = DATA_W'($signed(din) >>> n);
            cout = din[n - 1'b1];
          end
        end
        default: begin
          if (ctl.rorWrap) begin
            dout = din;
            cout = signBit;
          end else begin
            dout = dbl[n +: DATA_W];
            cout = din[n - 1'b1];
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/shift_carry_top.sv
module shift_carry_top
  import shift_carry_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int AMT_W = 8,
  parameter bit OUT_REG = 1'b0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] dataIn,
  input  logic [DATA_W-1:0] shAmt,
  input  logic [1:0]        shOp,
  output logic [DATA_W-1:0] result,
  output logic              carryOut,
  output logic              carryWe
);
  shCtl_t ctl;
  shKind_e kind;
  logic [AMT_W-1:0] amt;
  logic [DATA_W-1:0] resComb;
  logic carryComb;

  assign kind = shKind_e'(shOp);
  assign amt = shAmt[AMT_W-1:0];

  shift_carry_ctrl #(.AMT_W(AMT_W), .DATA_W(DATA_W)) uCtrl (
    .amt(amt), .kind(kind), .ctl(ctl)
  );

  shift_carry_dp #(.AMT_W(AMT_W), .DATA_W(DATA_W)) uDp (
    .din(dataIn), .amt(amt), .kind(kind), .ctl(ctl),
    .dout(resComb), .cout(carryComb)
  );

  generate
    if (OUT_REG) begin : gOutReg
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          result   <= '0;
          carryOut <= 1'b0;
          carryWe  <= 1'b0;
        end else begin
          result   <= resComb;
          carryOut <= carryComb;
          carryWe  <= ctl.carryWe;
        end
      end
    end else begin : gComb
      assign result   = resComb;
      assign carryOut = carryComb;
      assign carryWe  = ctl.carryWe;
    end
  endgenerate
endmodule

// File: rtl/shift_carry_chk.sv
module shift_carry_chk #(
  parameter int DATA_W = 32,
  parameter int AMT_W = 8,
  parameter bit OUT_REG = 1'b0
) (
  input logic              clk,
  input logic              rstN,
  input logic [DATA_W-1:0] dataIn,
  input logic [DATA_W-1:0] shAmt,
  input logic [1:0]        shOp,
  input logic [DATA_W-1:0] result,
  input logic              carryOut,
  input logic              carryWe
);
  logic [AMT_W-1:0] a;
  assign a = shAmt[AMT_W-1:0];

  generate
    if (!OUT_REG) begin : gCombChk
      // R2: zero amount passes data and holds carry
      p_zero_pass_r2: assert property (@(posedge clk) disable iff (!rstN)
        (a == '0) |-> (result == dataIn && !carryWe));
      // R3: left shift beyond width clears result and carry
      p_lsl_over_r3: assert property (@(posedge clk) disable iff (!rstN)
        (shOp == 2'b00 && 32'(a) > 32'(DATA_W)) |-> (result == '0 && !carryOut && carryWe));
      // R5: large arithmetic shift copies the sign everywhere
      p_asr_fill_r5: assert property (@(posedge clk) disable iff (!rstN)
        (shOp == 2'b10 && 32'(a) >= 32'(DATA_W)) |->
          (result == {DATA_W{dataIn[DATA_W-1]}} && carryOut == dataIn[DATA_W-1]));
      // R7: rotate by a multiple of the width keeps the data, carry from top bit
      p_ror_wrap_r7: assert property (@(posedge clk) disable iff (!rstN)
        (shOp == 2'b11 && a != '0 && (32'(a) % DATA_W) == 0) |->
          (result == dataIn && carryOut == dataIn[DATA_W-1] && carryWe));
    end else begin : gRegChk
      // R8: the registered stage reports the carry enable of the prior cycle's amount
      p_reg_lat_r8: assert property (@(posedge clk) disable iff (!rstN)
        $past(rstN) |-> (carryWe == ($past(a) != '0)));
      // R8: a zero amount one cycle earlier shows the earlier data
      p_reg_pass_r8: assert property (@(posedge clk) disable iff (!rstN)
        ($past(rstN) && $past(a) == '0) |-> (result == $past(dataIn)));
    end
  endgenerate
endmodule

bind shift_carry_top shift_carry_chk #(.DATA_W(DATA_W), .AMT_W(AMT_W), .OUT_REG(OUT_REG)) uChk (
  .clk(clk), .rstN(rstN), .dataIn(dataIn), .shAmt(shAmt), .shOp(shOp),
  .result(result), .carryOut(carryOut), .carryWe(carryWe)
);

// File: tb/tb_shift_carry_top.sv
module tb_shift_carry_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #5 clk = ~clk;

  logic [31:0] dIn, aIn, dInR, aInR;
  logic [1:0] opIn, opInR;
  logic [31:0] res, resR;
  logic cy, cyR, we, weR;

  int nChecks = 0;
  int nFails = 0;

  shift_carry_top #(.OUT_REG(1'b0)) dut (
    .clk(clk), .rstN(rstN), .dataIn(dIn), .shAmt(aIn), .shOp(opIn),
    .result(res), .carryOut(cy), .carryWe(we)
  );

  shift_carry_top #(.OUT_REG(1'b1)) dutReg (
    .clk(clk), .rstN(rstN), .dataIn(dInR), .shAmt(aInR), .shOp(opInR),
    .result(resR), .carryOut(cyR), .carryWe(weR)
  );

  // Independent model built one bit at a time from the requirements
  task automatic model(input logic [31:0] d, input logic [31:0] amtFull, input logic [1:0] op,
                       output logic [31:0] r, output logic c, output logic w);
    int n;
    n = int'(amtFull[7:0]);
    r = d; c = 1'b0; w = (n != 0);
    if (n != 0) begin
      case (op)
        2'b00: begin
          for (int i = 0; i < 32; i++) r[i] = (i - n >= 0) ? d[i - n] : 1'b0;
          c = (n <= 32) ? d[32 - n] : 1'b0;
        end
        2'b01: begin
          for (int i = 0; i < 32; i++) r[i] = (i + n < 32) ? d[i + n] : 1'b0;
          c = (n <= 32) ? d[n - 1] : 1'b0;
        end
        2'b10: begin
          for (int i = 0; i < 32; i++) r[i] = (i + n < 32) ? d[i + n] : d[31];
          c = (n < 32) ? d[n - 1] : d[31];
        end
        default: begin
          int m;
          m = n % 32;
          for (int i = 0; i < 32; i++) r[i] = d[(i + m) % 32];
          c = (m == 0) ? d[31] : d[m - 1];
        end
      endcase
    end
  endtask

  task automatic check(input string req, input logic [31:0] gotR, input logic gotC, input logic gotW,
                       input logic [31:0] expR, input logic expC, input logic expW);
    nChecks++;
    if (gotR !== expR || gotC !== expC || gotW !== expW) begin
      nFails++;
      $display("FAIL %s: got res=%h c=%b we=%b expected res=%h c=%b we=%b",
               req, gotR, gotC, gotW, expR, expC, expW);
    end
  endtask

  task automatic applyComb(input logic [31:0] d, input logic [31:0] a, input logic [1:0] op,
                           input string req);
    logic [31:0] er; logic ec, ew;
    @(negedge clk);
    dIn = d; aIn = a; opIn = op;
    #1;
    model(d, a, op, er, ec, ew);
    check(req, res, cy, we, er, ec, ew);
  endtask

  // R8: reset state of the registered instance
  task automatic testReset();
    #1;
    check("R8 reset", resR, cyR, weR, 32'h0, 1'b0, 1'b0);
  endtask

  // R2..R7: full sweep, every kind, every amount
  task automatic testSweep();
    for (int op = 0; op < 4; op++) begin
      for (int n = 0; n < 256; n++) begin
        string tag;
        case (op)
          0: tag = "R3 lsl";
          1: tag = "R4 lsr";
          2: tag = "R5 asr";
          default: tag = ((n % 32) == 0 && n != 0) ? "R7 ror wrap" : "R6 ror";
        endcase
        if (n == 0) tag = "R2 zero";
        applyComb($urandom(), 32'(n), 2'(op), tag);
        applyComb(32'h8000_0001, 32'(n), 2'(op), tag);
      end
    end
  endtask

  // R1: upper amount bits ignored
  task automatic testUpperBits();
    for (int k = 0; k < 64; k++) begin
      logic [31:0] a;
      a = $urandom();
      applyComb($urandom(), a, 2'(k % 4), "R1 upper bits");
    end
    applyComb(32'hdead_beef, 32'hffff_ff00, 2'b00, "R1 upper bits zero low");
    applyComb(32'hdead_beef, 32'h0000_0120, 2'b11, "R1 upper bits wrap");
  endtask

  // R8: one-cycle latency of registered stage
  task automatic testRegistered();
    logic [31:0] er; logic ec, ew;
    for (int k = 0; k < 40; k++) begin
      logic [31:0] d, a; logic [1:0] op;
      d = $urandom(); a = $urandom_range(0, 300); op = 2'($urandom());
      @(negedge clk);
      dInR = d; aInR = a; opInR = op;
      model(d, a, op, er, ec, ew);
      @(negedge clk);
      check("R8 registered", resR, cyR, weR, er, ec, ew);
    end
  endtask

  initial begin
    dIn = '0; aIn = '0; opIn = '0; dInR = '0; aInR = '0; opInR = '0;
    testReset();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testSweep();
    testUpperBits();
    testRegistered();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    #2000000;
    nFails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule